// File: doc/BRIEF.md
# SPI Slave Serial Shifter with Hold Pause

This block is the bit-level front end of a serial memory slave. It watches an active-low select, a serial clock, a serial data input and an active-low hold input. It assembles incoming bits into bytes and shifts outgoing bytes onto the serial output, most significant bit first. Both idle clock levels are accepted: clock resting low (mode 0) and clock resting high (mode 3). In both, data is taken on the rising edge and the output moves on the falling edge.

The pins are oversampled by the core clock through a synchronizer, and every serial edge is detected in the core clock domain. Each completed byte is reported with a one-cycle strobe. The command logic behind the shifter supplies the next byte to transmit on a parallel input. That byte is taken when select falls, and again at the first falling edge after each completed byte.

A hold input pauses a transfer mid-byte without losing the bit position. While held, the serial output is not driven, and the serial clock and data input are ignored. Hold is entered and left only on hold edges that occur while the clock is low. A deselect clears both the pause and the bit position.

Top module: `spi_hold_shifter`

## Requirements
- R1: While selected and not held, each rising serial clock edge captures one data-in bit, most significant bit first. After every eighth capture, `rx_valid_o` is high for exactly one core cycle, and `rx_byte_o` carries the assembled byte.
- R2: The serial output presents bit 7 of `tx_byte_i`, sampled at selection, before the first rising edge. Each falling edge that follows a capture moves the output to the next lower bit. The falling edge after the eighth capture loads a new `tx_byte_i` and presents its bit 7.
- R3: With the clock resting high at selection (mode 3), the falling edge before the first capture does not move the output. Mode 0 and mode 3 yield identical received and transmitted bytes.
- R4: `miso_oe_o` is high only while the block is selected and not held. It is low after reset and while deselected.
- R5: While selected, a falling hold input with the clock low enters hold, and `miso_oe_o` drops.
- R6: A falling hold input while the clock is high is ignored, and `miso_oe_o` stays high.
- R7: While held, clock and data-in edges are ignored: no bit is captured, the output bit does not move, and `rx_valid_o` stays low.
- R8: A rising hold input with the clock low leaves hold. Shifting then resumes at the same bit position in both directions.
- R9: Deselecting during hold clears the hold and the bit position. The next selection starts a fresh byte with a fresh `tx_byte_i` load.
- R10: After reset `rx_valid_o` and `miso_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Active-low hold request |
| tx_byte_i | input | DATA_W | Next byte to transmit, from the command logic |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the serial data out pad |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_byte_o | output | DATA_W | Last received byte |

## Verification
The bench pauses transfers mid-byte and toggles the clock and data while held. A design that counted those edges would report a corrupt byte, or an extra strobe. Hold edges are placed both while the clock is low and while it is high. A design that did not qualify hold by the clock level would float the output in the second case. Transfers run with the clock resting high, which catches a design that shifts on the leading falling edge and loses bit 7. A deselect during hold is followed by a fresh transfer, which exposes a bit counter or a pause that survives the deselect.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
    logic hold_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sck_i,
  input  logic hold_ni,
  output logic held_o
);
  logic hold_q, held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      held_q <= 1'b0;
    end else begin
      hold_q <= hold_ni;
      if (!sel_i)
        held_q <= 1'b0;
      else if (!sck_i) begin
        // only edges seen with the clock low count
        if (!held_q && hold_q && !hold_ni)      held_q <= 1'b1;
        else if (held_q && !hold_q && hold_ni)  held_q <= 1'b0;
      end
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sel_start_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q;
  logic [DATA_W-1:0] rx_sr_q, tx_sr_q, rx_byte_q;
  logic              rx_valid_q;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rx_sr_q[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      rx_byte_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (!sel_i) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        if (sel_start_i) tx_sr_q <= tx_byte_i;
        if (rise_i) begin
          rx_sr_q <= rx_next;
          pend_q  <= 1'b1;
          if (cnt_q == LAST) begin
            cnt_q      <= '0;
            rx_valid_q <= 1'b1;
            rx_byte_q  <= rx_next;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (fall_i && pend_q) begin
          // a leading fall with no capture yet (mode 3) is skipped
          pend_q  <= 1'b0;
          tx_sr_q <= (cnt_q == '0) ? tx_byte_i : {tx_sr_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_o     = tx_sr_q[DATA_W-1];
  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = rx_byte_q;
endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter
  import spi_hold_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_ni,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int unsigned PIN_W = $bits(spi_pins_t);

  spi_pins_t pins_raw, pins_s;
  logic sel_s, sck_s, mosi_s, hold_s;
  logic sel_q, sck_q, held;
  logic sel_start, sck_rise, sck_fall;

  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, mosi: mosi_i, hold_n: hold_ni};

  spi_hold_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_raw), .q_o(pins_s)
  );

  assign sel_s  = !pins_s.cs_n;
  assign sck_s  = pins_s.sck;
  assign mosi_s = pins_s.mosi;
  assign hold_s = pins_s.hold_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      sel_q <= sel_s;
      sck_q <= sck_s;
    end
  end

  assign sel_start = sel_s && !sel_q;
  assign sck_rise  = sel_s && !held && sck_s && !sck_q;
  assign sck_fall  = sel_s && !held && !sck_s && sck_q;

  spi_hold_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_s), .sck_i(sck_s),
    .hold_ni(hold_s), .held_o(held)
  );

  spi_hold_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_s), .sel_start_i(sel_start),
    .rise_i(sck_rise), .fall_i(sck_fall), .mosi_i(mosi_s), .tx_byte_i(tx_byte_i),
    .miso_o(miso_o), .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o)
  );

  assign miso_oe_o = sel_q && !held;
endmodule

// File: rtl/spi_hold_shifter_chk.sv
module spi_hold_shifter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_s,
  input logic sck_s,
  input logic hold_s,
  input logic held,
  input logic miso_oe_o,
  input logic rx_valid_o
);
  p_strobe_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_hold_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_s && $fell(hold_s) && !sck_s) |=> !miso_oe_o);

  p_hold_ignored_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held && $fell(hold_s) && sck_s) |=> !held);

  p_no_strobe_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |-> !rx_valid_o);

  p_deselect_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s |=> !held);
endmodule

bind spi_hold_shifter spi_hold_shifter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_s(sel_s), .sck_s(sck_s),
  .hold_s(hold_s), .held(held), .miso_oe_o(miso_oe_o), .rx_valid_o(rx_valid_o)
);

// File: tb/spi_hold_shifter_tb.sv
module spi_hold_shifter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, mosi = 1'b0, hold_ni = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic miso, miso_oe, rx_valid;
  logic [7:0] rx_byte;
  logic cpol = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_shifter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .mosi_i(mosi),
    .hold_ni(hold_ni), .tx_byte_i(tx_byte), .miso_o(miso), .miso_oe_o(miso_oe),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bytes as strobes appear (R1, R7)
  always @(negedge clk) begin
    if (rst_ni && rx_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected strobe", {24'h0, rx_byte}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_byte == e, "R1 received byte", {24'h0, rx_byte}, {24'h0, e});
      end
    end
  end

  task automatic sel_begin(input logic [7:0] first_tx);
    sck = cpol;
    tick(HALF);
    tx_byte = first_tx;
    cs_ni = 1'b0;
    tick(HALF);
  endtask

  task automatic sel_end();
    if (!cpol) begin sck = 1'b0; tick(HALF); end
    cs_ni = 1'b1;
    tick(HALF);
    check(miso_oe == 1'b0, "R4 oe off when deselected", {31'h0, miso_oe}, 32'h0);
  endtask

  // nbits bits of mo; expected output bits from ex; optional hold/ignore points
  task automatic xfer(input logic [7:0] mo, input logic [7:0] ex, input int nbits,
                      input int hold_at, input int ign_at, input string req);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      mosi = mo[7-i];
      tick(HALF);
      if (i == hold_at) begin
        hold_ni = 1'b0;
        tick(HALF);
        check(miso_oe == 1'b0, "R5 hold entry oe", {31'h0, miso_oe}, 32'h0);
        for (int k = 0; k < 2; k++) begin
          sck = 1'b1; mosi = ~mo[7-i]; tick(HALF);
          sck = 1'b0; tick(HALF);
        end
        mosi = mo[7-i];
        hold_ni = 1'b1;
        tick(HALF);
        check(miso_oe == 1'b1, "R8 hold exit oe", {31'h0, miso_oe}, 32'h1);
      end
      check(miso == ex[7-i], req, {31'h0, miso}, {31'h0, ex[7-i]});
      sck = 1'b1;
      tick(HALF);
      if (i == ign_at) begin
        hold_ni = 1'b0;
        tick(HALF);
        check(miso_oe == 1'b1, "R6 hold fall with clock high", {31'h0, miso_oe}, 32'h1);
        hold_ni = 1'b1;
        tick(HALF);
      end
    end
  endtask

  task automatic byte_io(input logic [7:0] mo, input logic [7:0] ex,
                         input int hold_at, input int ign_at, input string req);
    tx_byte = ex;
    exp_q.push_back(mo);
    xfer(mo, ex, 8, hold_at, ign_at, req);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // R10 reset state
    check(miso_oe == 1'b0, "R10 oe after reset", {31'h0, miso_oe}, 32'h0);
    check(rx_valid == 1'b0, "R10 strobe after reset", {31'h0, rx_valid}, 32'h0);

    // mode 0, two back-to-back bytes (R1, R2)
    cpol = 1'b0;
    sel_begin(8'hA5);
    check(miso_oe == 1'b1, "R4 oe while selected", {31'h0, miso_oe}, 32'h1);
    byte_io(8'h3C, 8'hA5, -1, -1, "R2 mode0 byte0 out");
    byte_io(8'hC3, 8'h5A, -1, -1, "R2 mode0 byte1 out");
    sel_end();

    // mode 3, same structure (R3)
    cpol = 1'b1;
    sel_begin(8'h0F);
    byte_io(8'h81, 8'h0F, -1, -1, "R3 mode3 byte0 out");
    byte_io(8'h7E, 8'hF0, -1, -1, "R3 mode3 byte1 out");
    sel_end();

    // hold mid-byte, mode 0 (R5, R7, R8)
    cpol = 1'b0;
    sel_begin(8'h69);
    byte_io(8'h96, 8'h69, 3, -1, "R8 resume after hold mode0");
    sel_end();

    // hold fall while clock high is ignored (R6)
    sel_begin(8'hAA);
    byte_io(8'h55, 8'hAA, -1, 5, "R6 byte after ignored hold");
    sel_end();

    // hold in mode 3 (R7, R8)
    cpol = 1'b1;
    sel_begin(8'h1E);
    byte_io(8'hE1, 8'h1E, 6, -1, "R7 resume after hold mode3");
    sel_end();

    // deselect while held, then fresh byte (R9)
    cpol = 1'b0;
    sel_begin(8'h33);
    xfer(8'hFF, 8'h33, 4, -1, -1, "R2 partial byte out");
    sck = 1'b0;
    tick(HALF);
    hold_ni = 1'b0;
    tick(HALF);
    cs_ni = 1'b1;
    tick(HALF);
    check(miso_oe == 1'b0, "R9 oe off after deselect in hold", {31'h0, miso_oe}, 32'h0);
    hold_ni = 1'b1;
    tick(HALF);
    sel_begin(8'hC6);
    check(miso_oe == 1'b1, "R9 not held after reselect", {31'h0, miso_oe}, 32'h1);
    byte_io(8'h24, 8'hC6, -1, -1, "R9 fresh byte out");
    sel_end();

    tick(HALF);
    check(exp_q.size() == 0, "R1 all bytes received", exp_q.size(), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule